// File: doc/BRIEF.md
# Right-Hand Wall-Following Steering Controller

This block is the decision core of a small maze-crawling robot that keeps a wall on its right-hand side. Two contact sensors report whether the left or the right feeler is pressed against a wall. From these, a four-state Moore machine chooses a movement command for each cycle: step forward, nudge left, nudge right, or a legal combination of these.

The controller has a two-bit state register and a purely combinational output decode. Because the outputs depend only on the state, a change on a sensor reaches the outputs one clock later. A synchronous active-high reset puts the machine into the searching state, in which it walks straight ahead until it meets a wall.

Top module: `wall_follow_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is SEEK (state code 2'b00). In SEEK the outputs are fwd=1, turn_l=0, turn_r=0.
- R2: In SEEK with both sensors at 0, the machine stays in SEEK. If either sensor is 1, the next state is PIVOT (2'b01).
- R3: In PIVOT the outputs are turn_l=1, fwd=0, turn_r=0. PIVOT holds while either sensor is 1 and moves to DRIFT (2'b11) when both sensors are 0.
- R4: In HUG (2'b10) the outputs are turn_l=1, fwd=1, turn_r=0. In DRIFT (2'b11) the outputs are turn_r=1, fwd=1, turn_l=0.
- R5: From HUG or DRIFT, sens_l=1 gives PIVOT whatever sens_r is. sens_l=0 with sens_r=1 gives HUG. Both sensors at 0 give DRIFT.
- R6: turn_l and turn_r are never 1 in the same cycle.
- R7: Outputs change only at a clock edge. When the state holds, a change on the sensors does not change the outputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset to SEEK |
| sens_l | input | 1 | Left feeler touching a wall |
| sens_r | input | 1 | Right feeler touching a wall |
| fwd | output | 1 | Step forward |
| turn_l | output | 1 | Turn slightly left |
| turn_r | output | 1 | Turn slightly right |
| state | output | 2 | Current state code |

## Verification
The assertions assume that both sensor bits are driven to known 0 or 1 values at every rising edge once reset has been released. They make no other assumption about the sensors, so any sequence of sensor values is legal. The stimulus changes the sensors only at the falling edge of the clock, which keeps every sampled value defined. The bench reaches each of the four states and then applies all four sensor combinations from that state. It also steps through a long sequence that wanders between the states. At every step it compares the state and the outputs with a transition table computed in the bench.

// File: rtl/wall_follow_ctrl.sv
module wall_follow_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       sens_l,
  input  logic       sens_r,
  output logic       fwd,
  output logic       turn_l,
  output logic       turn_r,
  output logic [1:0] state
);
  localparam logic [1:0] SEEK  = 2'b00;
  localparam logic [1:0] PIVOT = 2'b01;
  localparam logic [1:0] HUG   = 2'b10;
  localparam logic [1:0] DRIFT = 2'b11;

  logic [1:0] cur, nxt;

  always_comb begin
    nxt = cur;
    unique case (cur)
      SEEK:    nxt = (sens_l | sens_r) ? PIVOT : SEEK;
      PIVOT:   nxt = (sens_l | sens_r) ? PIVOT : DRIFT;
      default: nxt = sens_l ? PIVOT : (sens_r ? HUG : DRIFT);
    endcase
  end

  always_ff @(posedge clk)
    if (rst) cur <= SEEK;
    else     cur <= nxt;

  assign fwd    = (cur != PIVOT);
  assign turn_l = (cur == PIVOT) | (cur == HUG);
  assign turn_r = (cur == DRIFT);
  assign state  = cur;
endmodule

// File: rtl/wall_follow_ctrl_chk.sv
module wall_follow_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       sens_l,
  input logic       sens_r,
  input logic       fwd,
  input logic       turn_l,
  input logic       turn_r,
  input logic [1:0] state
);
  // R6
  turn_excl_chk: assert property (@(posedge clk) disable iff (rst) !(turn_l && turn_r));
  // R1
  reset_seek_chk: assert property (@(posedge clk) rst |=> (state == 2'b00));
  // R2
  seek_leave_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 2'b00 && (sens_l || sens_r)) |=> (state == 2'b01));
  // R3
  pivot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 2'b01 && (sens_l || sens_r)) |=> (state == 2'b01));
  // R5
  follow_left_chk: assert property (@(posedge clk) disable iff (rst)
    (state[1] && sens_l) |=> (state == 2'b01));
  // R5
  follow_right_chk: assert property (@(posedge clk) disable iff (rst)
    (state[1] && !sens_l && sens_r) |=> (state == 2'b10));
  // R7
  out_stable_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(state) |-> ($stable(fwd) && $stable(turn_l) && $stable(turn_r)));
endmodule

bind wall_follow_ctrl wall_follow_ctrl_chk i_chk (.*);

// File: tb/test_wall_follow_ctrl.sv
module test_wall_follow_ctrl;
  logic clk = 0, rst = 1, sl = 0, sr = 0;
  logic fwd, tl, tr;
  logic [1:0] st;
  int total = 0, bad = 0;
  logic [1:0] model;

  always #5 clk = ~clk;

  wall_follow_ctrl i_wall_follow_ctrl (.clk(clk), .rst(rst), .sens_l(sl), .sens_r(sr),
    .fwd(fwd), .turn_l(tl), .turn_r(tr), .state(st));

  function automatic logic [1:0] ref_next(input logic [1:0] s, input logic l, input logic r);
    if (s == 2'b00) return (l | r) ? 2'b01 : 2'b00;
    if (s == 2'b01) return (l | r) ? 2'b01 : 2'b11;
    return l ? 2'b01 : (r ? 2'b10 : 2'b11);
  endfunction

  function automatic logic [2:0] ref_out(input logic [1:0] s);
    case (s)  // {fwd, tl, tr}
      2'b00: return 3'b100;
      2'b01: return 3'b010;
      2'b10: return 3'b110;
      default: return 3'b101;
    endcase
  endfunction

  task automatic check(input string req);
    logic [2:0] exp_o = ref_out(model);
    total++;
    if (st !== model || {fwd, tl, tr} !== exp_o) begin
      bad++;
      $display("FAIL %s: state=%b out=%b expected state=%b out=%b", req, st, {fwd, tl, tr}, model, exp_o);
    end
    total++;
    if (tl && tr) begin
      bad++;
      $display("FAIL R6: turn_l=%b turn_r=%b expected not both", tl, tr);
    end
  endtask

  task automatic step(input logic l, input logic r, input string req);
    sl = l; sr = r;
    #1;
    // R7: same-cycle sensor change leaves outputs untouched
    check("R7");
    model = ref_next(model, l, r);
    @(negedge clk);
    check(req);
  endtask

  task automatic goto(input logic [1:0] s);
    rst = 1; @(negedge clk); rst = 0; model = 2'b00;
    case (s)
      2'b01: step(1, 0, "R2");
      2'b10: begin step(1, 0, "R2"); step(0, 0, "R3"); step(0, 1, "R5"); end
      2'b11: begin step(1, 0, "R2"); step(0, 0, "R3"); end
      default: ;
    endcase
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0; model = 2'b00;
    check("R1");
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 4; c++) begin
        goto(s[1:0]);
        step(c[1], c[0], s == 0 ? "R2" : s == 1 ? "R3" : "R5");
        check("R4");
      end
    rst = 1; @(negedge clk); rst = 0; model = 2'b00;
    for (int i = 0; i < 200; i++) begin
      int k = (i * 7 + i / 3) % 4;
      step(k[1], k[0], "R5");
    end
    sl = 1; rst = 1; @(negedge clk); model = 2'b00; check("R1");
    rst = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule